// File: doc/BRIEF.md
# FIFO-Threshold Interrupt and Status Unit

This block is the interrupt and status front of a command-driven serial engine. It watches three FIFO fill conditions and one event: the command queue running low, the transmit queue running low, the receive queue running high, and a sync marker reported by the engine. Each of the four conditions sets a bit in a pending register. The pending bits are masked by an enable register, and the result is combined into one interrupt line. A sync marker also stores its 8-bit tag, which software reads to learn which program has finished.

Software reaches the block through a plain word-addressed register port. It clears pending bits by writing ones to them. It can read the live room left in the command and transmit FIFOs and the fill level of the receive FIFO. It controls a soft-reset register that holds the serial engine in reset. The FIFOs and the engine are outside this block and appear only as level inputs and a sync strobe.

Top module: `evt_irq_unit`

## Requirements
- R1: After reset, the enable register reads 0, the pending register reads 0, the sync tag reads 0, the soft-reset register reads 1, `engine_hold` is 1 and `irq` is 0.
- R2: Pending bit 0 is set one cycle after `cmd_room` is at least `CMD_DEPTH - CMD_AE_MARGIN` (12 by default). A value of 11 does not set it.
- R3: Pending bit 1 is set one cycle after `tx_room` is at least `TX_DEPTH - TX_AE_MARGIN` (12 by default). A value of 11 does not set it.
- R4: Pending bit 2 is set one cycle after `rx_fill` is at least `RX_DEPTH - RX_AF_MARGIN` (12 by default). A value of 11 does not set it.
- R5: A cycle with `sync_strobe` high sets pending bit 3 and stores `sync_tag` in the tag register (word 2). A later strobe replaces the stored tag.
- R6: Writing the pending register (word 1) clears each bit whose write-data bit is 1 and leaves every other bit unchanged. Writing 0xFF clears all four bits. Writing 0 changes nothing.
- R7: A threshold bit (bits 0 to 2) remains set after a clear for as long as its condition still holds. It can only be cleared once the condition has gone away.
- R8: If a sync strobe and a write clearing bit 3 fall in the same cycle, bit 3 ends up set.
- R9: `irq` is 1 exactly when a pending bit and the matching bit of the enable register (word 0, bits 3:0) are both 1.
- R10: Reads of word 3, word 4 and word 5 return the current `cmd_room`, `tx_room` and `rx_fill` in the same cycle, zero-extended.
- R11: The soft-reset register (word 6, bit 0) drives `engine_hold`. Writing 0 releases the engine in the next cycle, and writing 1 holds it again.
- R12: Writes to the read-only words 2 to 5 have no effect on what they return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cmd_room | input | CMD_CW | Free entries in the command FIFO |
| tx_room | input | TX_CW | Free entries in the transmit FIFO |
| rx_fill | input | RX_CW | Occupied entries in the receive FIFO |
| sync_strobe | input | 1 | One-cycle sync marker from the engine |
| sync_tag | input | 8 | Tag that accompanies the sync marker |
| irq | output | 1 | Masked OR of the pending bits |
| engine_hold | output | 1 | Reset hold for the serial engine |

## Verification
Level inputs, the sync strobe and register writes are all sampled at one rising edge. Their effect on the pending bits, the tag register, the enable register, `engine_hold` and `irq` is therefore due one cycle later. The live FIFO readouts are combinational and are due in the same cycle. The bench drives inputs on the falling edge and reads one nanosecond after it. In that window every result produced by the preceding rising edge has settled and no new edge has arrived. Boundary tests hold a level one count below its threshold for a full cycle before checking that the pending bit stayed clear.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int REG_AW  = 4;
  localparam int REG_DW  = 32;
  localparam int NUM_SRC = 4;
  localparam int TAG_W   = 8;

  // Pending / enable bit positions; software decodes these.
  localparam int BIT_CMD_LOW  = 0;
  localparam int BIT_TX_LOW   = 1;
  localparam int BIT_RX_HIGH  = 2;
  localparam int BIT_SYNC     = 3;

  typedef enum logic [REG_AW-1:0] {
    WA_ENABLE  = 4'h0,
    WA_PENDING = 4'h1,
    WA_TAG     = 4'h2,
    WA_CMDROOM = 4'h3,
    WA_TXROOM  = 4'h4,
    WA_RXFILL  = 4'h5,
    WA_HOLD    = 4'h6
  } word_addr_e;

endpackage

// File: rtl/evt_level_detect.sv
module evt_level_detect #(
  parameter int CW     = 5,
  parameter int THRESH = 12
) (
  input  logic [CW-1:0] level,
  output logic          hit
);

  localparam logic [31:0] THR_W = THRESH;

  always_comb begin
    hit = (32'(level) >= THR_W);
  end

endmodule

// File: rtl/evt_pending_bank.sv
module evt_pending_bank
  import evt_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ns,
  input  logic [NUM_SRC-1:0] set_req,
  input  logic [NUM_SRC-1:0] clr_req,
  input  logic [NUM_SRC-1:0] enable_q,
  output logic [NUM_SRC-1:0] pend_q,
  output logic               irq
);

  logic [NUM_SRC-1:0] pend_d;
  logic [NUM_SRC-1:0] pend_ce;

  // Each bit: set request dominates over a simultaneous clear.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_comb begin
      pend_ce[i] = set_req[i] | clr_req[i];
      pend_d[i]  = set_req[i] | (pend_q[i] & ~clr_req[i]);
    end

    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns) begin
        pend_q[i] <= 1'b0;
      end else if (pend_ce[i]) begin
        pend_q[i] <= pend_d[i];
      end
    end
  end

  always_comb begin
    irq = |(pend_q & enable_q);
  end

endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import evt_irq_pkg::*;
#(
  parameter int CMD_CW = 5,
  parameter int TX_CW  = 5,
  parameter int RX_CW  = 5
) (
  input  logic               clk,
  input  logic               rst_ns,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  input  logic [CMD_CW-1:0]  cmd_room,
  input  logic [TX_CW-1:0]   tx_room,
  input  logic [RX_CW-1:0]   rx_fill,
  input  logic               sync_strobe,
  input  logic [TAG_W-1:0]   sync_tag,
  input  logic [NUM_SRC-1:0] pend_q,
  output logic [NUM_SRC-1:0] clr_req,
  output logic [NUM_SRC-1:0] enable_q,
  output logic               hold_q
);

  logic               en_ce;
  logic [NUM_SRC-1:0] en_d;
  logic               hold_ce;
  logic               hold_d;
  logic               tag_ce;
  logic [TAG_W-1:0]   tag_d;
  logic [TAG_W-1:0]   tag_q;

  // Write decode and next-state values.
  always_comb begin
    en_ce   = reg_we && (reg_addr == WA_ENABLE);
    en_d    = reg_wdata[NUM_SRC-1:0];
    hold_ce = reg_we && (reg_addr == WA_HOLD);
    hold_d  = reg_wdata[0];
    tag_ce  = sync_strobe;
    tag_d   = sync_tag;
    clr_req = (reg_we && (reg_addr == WA_PENDING)) ? reg_wdata[NUM_SRC-1:0]
                                                   : '0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      enable_q <= '0;
    end else if (en_ce) begin
      enable_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      hold_q <= 1'b1;
    end else if (hold_ce) begin
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      tag_q <= '0;
    end else if (tag_ce) begin
      tag_q <= tag_d;
    end
  end

  // Read multiplexer.
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      WA_ENABLE:  reg_rdata = REG_DW'(enable_q);
      WA_PENDING: reg_rdata = REG_DW'(pend_q);
      WA_TAG:     reg_rdata = REG_DW'(tag_q);
      WA_CMDROOM: reg_rdata = REG_DW'(cmd_room);
      WA_TXROOM:  reg_rdata = REG_DW'(tx_room);
      WA_RXFILL:  reg_rdata = REG_DW'(rx_fill);
      WA_HOLD:    reg_rdata = REG_DW'(hold_q);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int CMD_DEPTH     = 16,
  parameter int TX_DEPTH      = 16,
  parameter int RX_DEPTH      = 16,
  parameter int CMD_AE_MARGIN = CMD_DEPTH / 4,
  parameter int TX_AE_MARGIN  = TX_DEPTH / 4,
  parameter int RX_AF_MARGIN  = RX_DEPTH / 4,
  parameter int CMD_CW        = $clog2(CMD_DEPTH + 1),
  parameter int TX_CW         = $clog2(TX_DEPTH + 1),
  parameter int RX_CW         = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [CMD_CW-1:0] cmd_room,
  input  logic [TX_CW-1:0]  tx_room,
  input  logic [RX_CW-1:0]  rx_fill,
  input  logic              sync_strobe,
  input  logic [TAG_W-1:0]  sync_tag,
  output logic              irq,
  output logic              engine_hold
);

  localparam int CMD_ROOM_THR = CMD_DEPTH - CMD_AE_MARGIN;
  localparam int TX_ROOM_THR  = TX_DEPTH - TX_AE_MARGIN;
  localparam int RX_FILL_THR  = RX_DEPTH - RX_AF_MARGIN;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_pipe;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  always_comb begin
    rst_ns = rst_pipe[1];
  end

  logic               cmd_hit;
  logic               tx_hit;
  logic               rx_hit;
  logic [NUM_SRC-1:0] set_req;
  logic [NUM_SRC-1:0] clr_req;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] pend_q;
  logic               hold_q;

  evt_level_detect #(.CW(CMD_CW), .THRESH(CMD_ROOM_THR)) u_cmd_det (
    .level (cmd_room),
    .hit   (cmd_hit)
  );

  evt_level_detect #(.CW(TX_CW), .THRESH(TX_ROOM_THR)) u_tx_det (
    .level (tx_room),
    .hit   (tx_hit)
  );

  evt_level_detect #(.CW(RX_CW), .THRESH(RX_FILL_THR)) u_rx_det (
    .level (rx_fill),
    .hit   (rx_hit)
  );

  always_comb begin
    set_req              = '0;
    set_req[BIT_CMD_LOW] = cmd_hit;
    set_req[BIT_TX_LOW]  = tx_hit;
    set_req[BIT_RX_HIGH] = rx_hit;
    set_req[BIT_SYNC]    = sync_strobe;
  end

  evt_reg_port #(.CMD_CW(CMD_CW), .TX_CW(TX_CW), .RX_CW(RX_CW)) u_regs (
    .clk         (clk),
    .rst_ns      (rst_ns),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cmd_room    (cmd_room),
    .tx_room     (tx_room),
    .rx_fill     (rx_fill),
    .sync_strobe (sync_strobe),
    .sync_tag    (sync_tag),
    .pend_q      (pend_q),
    .clr_req     (clr_req),
    .enable_q    (enable_q),
    .hold_q      (hold_q)
  );

  evt_pending_bank u_pend (
    .clk      (clk),
    .rst_ns   (rst_ns),
    .set_req  (set_req),
    .clr_req  (clr_req),
    .enable_q (enable_q),
    .pend_q   (pend_q),
    .irq      (irq)
  );

  always_comb begin
    engine_hold = hold_q;
  end

endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk
  import evt_irq_pkg::*;
#(
  parameter int CMD_CW  = 5,
  parameter int TX_CW   = 5,
  parameter int RX_CW   = 5,
  parameter int CMD_THR = 12,
  parameter int TX_THR  = 12,
  parameter int RX_THR  = 12
) (
  input logic               clk,
  input logic               rst_ns,
  input logic               reg_we,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [REG_DW-1:0]  reg_wdata,
  input logic [CMD_CW-1:0]  cmd_room,
  input logic [TX_CW-1:0]   tx_room,
  input logic [RX_CW-1:0]   rx_fill,
  input logic               sync_strobe,
  input logic [TAG_W-1:0]   sync_tag,
  input logic [REG_DW-1:0]  reg_rdata,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] enable_q,
  input logic               irq,
  input logic               engine_hold
);

  logic pend_wr;
  logic hold_wr;
  always_comb begin
    pend_wr = reg_we && (reg_addr == WA_PENDING);
    hold_wr = reg_we && (reg_addr == WA_HOLD);
  end

  AST_CMD_SETS: assert property (@(posedge clk) disable iff (!rst_ns)
    (32'(cmd_room) >= CMD_THR) |=> pend_q[BIT_CMD_LOW]); // R2
  AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_ns)
    (32'(tx_room) >= TX_THR) |=> pend_q[BIT_TX_LOW]); // R3
  AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_ns)
    (32'(rx_fill) >= RX_THR) |=> pend_q[BIT_RX_HIGH]); // R4
  AST_SYNC_SETS: assert property (@(posedge clk) disable iff (!rst_ns)
    sync_strobe |=> pend_q[BIT_SYNC]); // R5
  AST_SYNC_RACE: assert property (@(posedge clk) disable iff (!rst_ns)
    (sync_strobe && pend_wr && reg_wdata[BIT_SYNC]) |=> pend_q[BIT_SYNC]); // R8
  AST_TX_CLEARS: assert property (@(posedge clk) disable iff (!rst_ns)
    (pend_wr && reg_wdata[BIT_TX_LOW] && (32'(tx_room) < TX_THR)) |=> !pend_q[BIT_TX_LOW]); // R6
  AST_NO_SPONTANEOUS_FALL: assert property (@(posedge clk) disable iff (!rst_ns)
    !pend_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q))); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_ns)
    (enable_q == '0) |-> !irq); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_ns)
    (hold_wr && !reg_wdata[0]) |=> !engine_hold); // R11
  AST_ROOM_READ: assert property (@(posedge clk) disable iff (!rst_ns)
    (reg_addr == WA_CMDROOM) |-> (reg_rdata == REG_DW'(cmd_room))); // R10

endmodule

bind evt_irq_unit evt_irq_unit_chk #(
  .CMD_CW  (CMD_CW),
  .TX_CW   (TX_CW),
  .RX_CW   (RX_CW),
  .CMD_THR (CMD_ROOM_THR),
  .TX_THR  (TX_ROOM_THR),
  .RX_THR  (RX_FILL_THR)
) u_chk (
  .clk         (clk),
  .rst_ns      (rst_ns),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .cmd_room    (cmd_room),
  .tx_room     (tx_room),
  .rx_fill     (rx_fill),
  .sync_strobe (sync_strobe),
  .sync_tag    (sync_tag),
  .reg_rdata   (reg_rdata),
  .pend_q      (pend_q),
  .enable_q    (enable_q),
  .irq         (irq),
  .engine_hold (engine_hold)
);

// File: tb/evt_irq_unit_bench.sv
`timescale 1ns/1ps
module evt_irq_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [4:0]  cmd_room;
  logic [4:0]  tx_room;
  logic [4:0]  rx_fill;
  logic        sync_strobe;
  logic [7:0]  sync_tag;
  logic        irq;
  logic        engine_hold;

  int n_chk;
  int n_bad;
  bit done;

  evt_irq_unit u_evt_irq_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .cmd_room    (cmd_room),
    .tx_room     (tx_room),
    .rx_fill     (rx_fill),
    .sync_strobe (sync_strobe),
    .sync_tag    (sync_tag),
    .irq         (irq),
    .engine_hold (engine_hold)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Read a word: address set after a falling edge, sampled 1 ns later.
  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic pulse_sync(input logic [7:0] tag);
    @(negedge clk);
    sync_strobe = 1'b1; sync_tag = tag;
    @(negedge clk);
    sync_strobe = 1'b0; sync_tag = '0;
  endtask

  task automatic idle_levels();
    @(negedge clk);
    cmd_room = 5'd4; tx_room = 5'd4; rx_fill = 5'd0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); check("R1 enable", d, 0);
    rd(4'h1, d); check("R1 pending", d, 0);
    rd(4'h2, d); check("R1 tag", d, 0);
    rd(4'h6, d); check("R1 hold reg", d, 1);
    check("R1 engine_hold", 32'(engine_hold), 1);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_readouts();
    logic [31:0] d;
    @(negedge clk);
    cmd_room = 5'd7; tx_room = 5'd9; rx_fill = 5'd3;
    rd(4'h3, d); check("R10 cmd room", d, 7);
    rd(4'h4, d); check("R10 tx room", d, 9);
    rd(4'h5, d); check("R10 rx fill", d, 3);
    wr(4'h2, 32'hAB);
    wr(4'h3, 32'h1F);
    rd(4'h2, d); check("R12 tag unchanged", d, 0);
    rd(4'h3, d); check("R12 cmd room unchanged", d, 7);
    rd(4'h1, d); check("R12 no pending", d, 0);
    idle_levels();
  endtask

  task automatic t_hold();
    logic [31:0] d;
    wr(4'h6, 32'h0);
    check("R11 released", 32'(engine_hold), 0);
    rd(4'h6, d); check("R11 reg reads 0", d, 0);
    wr(4'h6, 32'h1);
    check("R11 held again", 32'(engine_hold), 1);
  endtask

  task automatic t_thresholds();
    logic [31:0] d;
    // just below each threshold: nothing latches
    @(negedge clk);
    cmd_room = 5'd11; tx_room = 5'd11; rx_fill = 5'd11;
    rd(4'h1, d); check("R2 R3 R4 below threshold", d, 0);
    @(negedge clk); cmd_room = 5'd12;
    rd(4'h1, d); check("R2 cmd low sets bit0", d, 32'h1);
    @(negedge clk); cmd_room = 5'd4;
    wr(4'h1, 32'h1);
    @(negedge clk); tx_room = 5'd12;
    rd(4'h1, d); check("R3 tx low sets bit1", d, 32'h2);
    @(negedge clk); tx_room = 5'd4;
    wr(4'h1, 32'h2);
    @(negedge clk); rx_fill = 5'd12;
    rd(4'h1, d); check("R4 rx high sets bit2", d, 32'h4);
    @(negedge clk); rx_fill = 5'd0;
    wr(4'h1, 32'h4);
    rd(4'h1, d); check("R6 cleared after sources drop", d, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    @(negedge clk); tx_room = 5'd16;
    wr(4'h1, 32'h2);
    rd(4'h1, d); check("R7 bit1 reasserts while condition holds", d, 32'h2);
    @(negedge clk); tx_room = 5'd4;
    wr(4'h1, 32'h2);
    rd(4'h1, d); check("R7 bit1 clears once condition gone", d, 0);
  endtask

  task automatic t_sync();
    logic [31:0] d;
    pulse_sync(8'h5A);
    rd(4'h1, d); check("R5 sync sets bit3", d, 32'h8);
    rd(4'h2, d); check("R5 tag stored", d, 32'h5A);
    pulse_sync(8'hC3);
    rd(4'h2, d); check("R5 tag replaced", d, 32'hC3);
    wr(4'h1, 32'h8);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    @(negedge clk); cmd_room = 5'd16; tx_room = 5'd16; rx_fill = 5'd16;
    @(negedge clk); cmd_room = 5'd4; tx_room = 5'd4; rx_fill = 5'd0;
    pulse_sync(8'h11);
    rd(4'h1, d); check("R6 all four set", d, 32'hF);
    wr(4'h1, 32'h0);
    rd(4'h1, d); check("R6 write 0 no change", d, 32'hF);
    wr(4'h1, 32'h5);
    rd(4'h1, d); check("R6 selective clear", d, 32'hA);
    wr(4'h1, 32'hFF);
    rd(4'h1, d); check("R6 clear all", d, 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    @(negedge clk);
    sync_strobe = 1'b1; sync_tag = 8'h77;
    reg_we = 1'b1; reg_addr = 4'h1; reg_wdata = 32'h8;
    @(negedge clk);
    sync_strobe = 1'b0; sync_tag = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(4'h1, d); check("R8 sync beats clear", d, 32'h8);
    rd(4'h2, d); check("R8 tag of racing sync", d, 32'h77);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    // bit3 pending from previous task
    check("R9 disabled no irq", 32'(irq), 0);
    wr(4'h0, 32'h7);
    check("R9 other bits enabled no irq", 32'(irq), 0);
    wr(4'h0, 32'h8);
    check("R9 matching enable irq", 32'(irq), 1);
    rd(4'h0, d); check("R9 enable readback", d, 32'h8);
    wr(4'h1, 32'h8);
    check("R9 irq drops after clear", 32'(irq), 0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    cmd_room = 5'd4; tx_room = 5'd4; rx_fill = 5'd0;
    sync_strobe = 1'b0; sync_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readouts();
    t_hold();
    t_thresholds();
    t_sticky();
    t_sync();
    t_w1c();
    t_race();
    t_irq();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule